// File: doc/BRIEF.md
# Serial-Bus Slave Error Status Register

This block holds the error status of a serial control-bus slave. The frame decoder sends it single-cycle pulses for seven kinds of fault. Each pulse sets a sticky flag. The seven faults are:

- a parity error in a command frame;
- a command cut short by a new sequence start;
- a parity error in an address frame;
- a parity error in a data frame;
- a read of an address that maps to nothing;
- a write to an address that maps to nothing;
- a read carrying the broadcast ID.

The flags are kept in one 8-bit register. The top bit of that register is not a flag: it is a soft-reset command that can only be written.

When the register is read with the device's unique ID, the block returns the flags and drives a clear-on-read pulse. The flags then clear themselves on the next edge. A soft-reset write counts only if it comes in a frame addressed with the unique ID. It is held pending until the decoder's end-of-frame strobe, and it comes out as a one-cycle pulse on that last frame cycle. Other registers use this pulse as their reset. The flags are wiped on the same edge.

Entering the startup power mode also wipes the flags and cancels a pending soft reset. The status register can always be read, even while general read access is turned off. While reads are off, a unique-ID read of any other address sets the read-unmapped flag and gets no response.

Top module: `err_status_reg`

## Requirements
- R1: A read with `acc_valid_i`=1, `acc_write_i`=0, `acc_addr_i`=STATUS_ADDR (default 0x1A) and `acc_id_i`=2'b00 (unique) asserts `rd_valid_o` in that same cycle. In that cycle `rd_data_o` carries the flags: bit 6 command parity, bit 5 command length, bit 4 address parity, bit 3 data parity, bit 2 read-unmapped, bit 1 write-unmapped, bit 0 broadcast-read. When there is no such read, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: A 1 on bit k of `evt_i` (same bit order as R1) sets flag k at the next clock edge. The flag stays set until it is cleared.
- R3: A bus write to the status address cannot change flags [6:0], whatever the data and ID.
- R4: A read as in R1 pulses `clr_on_read_o` in the same cycle. All flags are 0 after the next edge.
- R5: If an event arrives in the same cycle as a clearing read, its flag is 1 after that edge.
- R6: Bit 7 of `rd_data_o` always reads 0.
- R7: A write to the status address with `acc_wdata_i[7]`=1 and `acc_id_i`=2'b00 arms a soft reset. `soft_rst_o` pulses in the cycle where `frame_end_i`=1, which may be the write cycle itself. After that edge every flag is 0, including flags whose events arrived in the pulse cycle. The end of the frame disarms the soft reset.
- R8: A soft-reset write with `acc_id_i`=2'b01 (group) or 2'b10 (broadcast) produces no `soft_rst_o` pulse and leaves the flags unchanged.
- R9: A 1 on `startup_i` makes all flags 0 after the next edge and cancels an armed soft reset.
- R10: Take a unique-ID read of an address other than STATUS_ADDR. With `rd_enable_i`=0 it sets flag 2 and gets no `rd_valid_o`. With `rd_enable_i`=1 it sets no flag.
- R11: A read of STATUS_ADDR with a group or broadcast ID gets no `rd_valid_o` and does not clear the flags.
- R12: After power-up reset (`rst_ni` low) all flags are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| startup_i | input | 1 | Pulse: power mode passes through startup |
| evt_i | input | 7 | Error event pulses from the decoder, in flag bit order |
| acc_valid_i | input | 1 | A register access is present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 5 | Register address of the access |
| acc_wdata_i | input | 8 | Write data |
| acc_id_i | input | 2 | ID kind: 00 unique, 01 group, 10 broadcast |
| frame_end_i | input | 1 | Last clock cycle of the current frame |
| rd_enable_i | input | 1 | General read access enabled |
| rd_data_o | output | 8 | Status read data |
| rd_valid_o | output | 1 | The status register answers this read |
| clr_on_read_o | output | 1 | Pulse: flags clear at the next edge |
| soft_rst_o | output | 1 | Soft-reset pulse to the other registers |

## Verification
The bench drives several patterns, and each one separates a different set of faults:

- **Single events, then a read.** One event bit at a time, followed by a status read, shows whether any flag has moved to the wrong bit.
- **Coincident events.** Events that arrive in the same cycle as a clearing read, a soft-reset pulse or a startup pulse tell apart the three priorities: a read yields to new events, while a soft reset or startup overrides them.
- **Soft-reset variants.** Soft-reset writes are sent with the strobe in the same cycle, with the strobe some cycles later, and with group and broadcast IDs. These separate the pending-arm path from the same-cycle path and from the ID qualification.
- **Other-address reads.** Reads of other addresses with reads enabled and disabled check the read-unmapped rule.
- **Random traffic.** A long random stream follows, compared each cycle against the reference model.

// File: rtl/err_status_pkg.sv
package err_status_pkg;

  typedef enum logic [1:0] {
    ID_UNIQUE = 2'b00,
    ID_GROUP  = 2'b01,
    ID_BCAST  = 2'b10,
    ID_RSVD   = 2'b11
  } id_kind_e;

  // position of the flag that the status block sets on its own
  localparam int unsigned FLAG_RD_UNMAPPED = 2;

  // one flag bit: wipe beats everything, a new event beats clear-on-read
  function automatic logic flag_next(logic cur, logic set, logic rd_clr, logic wipe);
    return wipe ? 1'b0 : ((cur & ~rd_clr) | set);
  endfunction

  // an armed soft reset leaves the pending state at frame end or on startup
  function automatic logic pend_next(logic armed, logic frame_end, logic startup);
    return (frame_end | startup) ? 1'b0 : armed;
  endfunction

endpackage

// File: rtl/err_status_access.sv
module err_status_access
  import err_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h1A
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_sr_bit,
  input  logic [1:0]        acc_id,
  input  logic              rd_enable,
  output logic              rd_hit,
  output logic              rd_unmapped,
  output logic              sr_qual
);

  logic     addr_match;
  logic     is_unique;
  logic     is_read;
  logic     is_write;
  id_kind_e id_kind;

  always_comb begin
    id_kind    = id_kind_e'(acc_id);
    is_unique  = (id_kind == ID_UNIQUE);
    addr_match = (acc_addr == STATUS_ADDR);
    is_read    = acc_valid & ~acc_write;
    is_write   = acc_valid & acc_write;
  end

  // status register answers unique-ID reads regardless of the read enable
  assign rd_hit      = is_read & is_unique & addr_match;
  // any other unique-ID read while reads are off is flagged and unanswered
  assign rd_unmapped = is_read & is_unique & ~addr_match & ~rd_enable;
  // soft-reset command: unique ID only, group and broadcast dropped
  assign sr_qual     = is_write & is_unique & addr_match & acc_sr_bit;

endmodule

// File: rtl/err_status_softrst.sv
module err_status_softrst
  import err_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sr_qual,
  input  logic frame_end,
  input  logic startup,
  output logic sr_pulse
);

  logic pend_q;
  logic armed;

  assign armed    = pend_q | sr_qual;
  assign sr_pulse = frame_end & armed & ~startup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_next(armed, frame_end, startup);
  end

endmodule

// File: rtl/err_status_flags.sv
module err_status_flags
  import err_status_pkg::*;
#(
  parameter int unsigned NFLAG        = 7,
  parameter int unsigned UNMAPPED_BIT = FLAG_RD_UNMAPPED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             rd_unmapped,
  input  logic             rd_clr,
  input  logic             wipe,
  output logic [NFLAG-1:0] flags
);

  logic [NFLAG-1:0] set_vec;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == UNMAPPED_BIT) begin : g_self
      assign set_vec[i] = evt[i] | rd_unmapped;
    end else begin : g_ext
      assign set_vec[i] = evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], set_vec[i], rd_clr, wipe);
    end
  end

endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 5'h1A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              startup_i,
  input  logic [DATA_W-2:0] evt_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic [1:0]        acc_id_i,
  input  logic              frame_end_i,
  input  logic              rd_enable_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              clr_on_read_o,
  output logic              soft_rst_o
);

  localparam int unsigned NFLAG  = DATA_W - 1;
  localparam int unsigned SR_BIT = DATA_W - 1;

  logic             rd_hit;
  logic             rd_unmapped;
  logic             sr_qual;
  logic             sr_pulse;
  logic             wipe;
  logic [NFLAG-1:0] flags_q;
  logic             unused_wdata;

  // flag bits of the write data are not writable
  assign unused_wdata = ^acc_wdata_i[SR_BIT-1:0];

  err_status_access #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR)
  ) access_i (
    .acc_valid   (acc_valid_i),
    .acc_write   (acc_write_i),
    .acc_addr    (acc_addr_i),
    .acc_sr_bit  (acc_wdata_i[SR_BIT]),
    .acc_id      (acc_id_i),
    .rd_enable   (rd_enable_i),
    .rd_hit      (rd_hit),
    .rd_unmapped (rd_unmapped),
    .sr_qual     (sr_qual)
  );

  err_status_softrst softrst_i (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .sr_qual   (sr_qual),
    .frame_end (frame_end_i),
    .startup   (startup_i),
    .sr_pulse  (sr_pulse)
  );

  assign wipe = sr_pulse | startup_i;

  err_status_flags #(
    .NFLAG        (NFLAG),
    .UNMAPPED_BIT (FLAG_RD_UNMAPPED)
  ) flags_i (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .evt         (evt_i),
    .rd_unmapped (rd_unmapped),
    .rd_clr      (rd_hit),
    .wipe        (wipe),
    .flags       (flags_q)
  );

  // soft-reset bit is write-only and always returns 0
  assign rd_data_o     = rd_hit ? {1'b0, flags_q} : '0;
  assign rd_valid_o    = rd_hit;
  assign clr_on_read_o = rd_hit;
  assign soft_rst_o    = sr_pulse;

endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int unsigned NFLAG = 7,
  parameter int unsigned UNM   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             startup_i,
  input logic [NFLAG-1:0] evt_i,
  input logic             frame_end_i,
  input logic             rd_valid_o,
  input logic             clr_on_read_o,
  input logic             soft_rst_o,
  input logic [NFLAG-1:0] flags_q,
  input logic             rd_unmapped
);

  logic [NFLAG-1:0] set_vec;
  assign set_vec = evt_i | (NFLAG'(rd_unmapped) << UNM);

  p_sr_on_frame_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> frame_end_i);

  p_sr_wipes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (flags_q == '0));

  p_startup_wipes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    startup_i |=> (flags_q == '0));

  p_evt_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_o && !startup_i) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_on_read_o && !soft_rst_o && !startup_i && set_vec == '0) |=> (flags_q == '0));

  p_no_spurious_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_vec)) == '0));

  p_unmapped_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unmapped |-> !rd_valid_o);

endmodule

bind err_status_reg err_status_chk #(
  .NFLAG (NFLAG),
  .UNM   (err_status_pkg::FLAG_RD_UNMAPPED)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .startup_i     (startup_i),
  .evt_i         (evt_i),
  .frame_end_i   (frame_end_i),
  .rd_valid_o    (rd_valid_o),
  .clr_on_read_o (clr_on_read_o),
  .soft_rst_o    (soft_rst_o),
  .flags_q       (flags_q),
  .rd_unmapped   (rd_unmapped)
);

// File: tb/err_status_reg_tb_top.sv
`timescale 1ns/1ps
module err_status_reg_tb_top;

  localparam int CLK_HALF = 5;
  localparam logic [4:0] SADDR = 5'h1A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startup;
  logic [6:0] evt;
  logic       acc_valid, acc_write, frame_end, rd_en;
  logic [4:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [1:0] acc_id;
  logic [7:0] rd_data;
  logic       rd_valid, clr_rd, soft_rst;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit [6:0] m_flags = '0;
  bit       m_pend  = 1'b0;

  always #CLK_HALF clk = ~clk;

  err_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .startup_i(startup), .evt_i(evt),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_id_i(acc_id), .frame_end_i(frame_end),
    .rd_enable_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .clr_on_read_o(clr_rd), .soft_rst_o(soft_rst)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    startup = 0; evt = '0; acc_valid = 0; acc_write = 0; acc_addr = '0;
    acc_wdata = '0; acc_id = 2'b00; frame_end = 0; rd_en = 0;
  endtask

  // one clock cycle: inputs already driven after a falling edge
  task automatic tick(input string tag);
    bit hit, unm, qual, sr;
    bit [7:0] exp_data;
    #1;
    hit  = acc_valid && !acc_write && acc_addr == SADDR && acc_id == 2'b00;
    unm  = acc_valid && !acc_write && acc_addr != SADDR && acc_id == 2'b00 && !rd_en;
    qual = acc_valid && acc_write && acc_addr == SADDR && acc_id == 2'b00 && acc_wdata[7];
    sr   = frame_end && (m_pend || qual) && !startup;
    exp_data = hit ? {1'b0, m_flags} : 8'h00;
    check({tag, " rd_data"}, {24'h0, rd_data}, {24'h0, exp_data});
    check({tag, " strobes"}, {29'h0, rd_valid, clr_rd, soft_rst}, {29'h0, hit, hit, sr});
    @(posedge clk);
    if (startup || sr) begin
      m_flags = '0;
      m_pend  = 0;
    end else begin
      if (hit) m_flags = '0;
      m_flags = m_flags | evt | (unm ? 7'b0000100 : 7'b0);
      m_pend  = frame_end ? 1'b0 : (m_pend || qual);
    end
    @(negedge clk);
    set_idle();
  endtask

  task automatic do_evt(input bit [6:0] e, input string tag);
    evt = e; tick(tag);
  endtask

  task automatic do_read(input bit [4:0] a, input bit [1:0] id, input bit en,
                         input bit [6:0] e, input string tag);
    acc_valid = 1; acc_write = 0; acc_addr = a; acc_id = id; rd_en = en; evt = e;
    tick(tag);
  endtask

  task automatic do_write(input bit [7:0] d, input bit [1:0] id, input bit fe,
                          input bit [6:0] e, input string tag);
    acc_valid = 1; acc_write = 1; acc_addr = SADDR; acc_wdata = d; acc_id = id;
    frame_end = fe; evt = e;
    tick(tag);
  endtask

  task automatic idle_cycles(input int n, input bit fe_last, input string tag);
    for (int i = 0; i < n; i++) begin
      frame_end = fe_last && (i == n - 1);
      tick(tag);
    end
  endtask

  initial begin
    #(2 * CLK_HALF * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_idle();
    repeat (3) @(negedge clk);
    // R12: outputs quiet while held in reset
    check("R12 reset outputs", {21'h0, rd_data, rd_valid, clr_rd, soft_rst}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    do_read(SADDR, 2'b00, 0, 0, "R12 R1 first read");

    // R2 / R1: each bit on its own
    for (int k = 0; k < 7; k++) begin
      do_evt(7'(1 << k), "R2 single event");
      idle_cycles(2, 0, "R2 hold");
      do_read(SADDR, 2'b00, 0, 0, "R1 R6 bit position read");
      do_read(SADDR, 2'b00, 0, 0, "R4 cleared after read");
    end

    // R3: bus writes cannot touch the flags
    do_evt(7'h55, "R2 multi event");
    do_write(8'h00, 2'b00, 1, 0, "R3 write zeros");
    do_write(8'h7F, 2'b00, 1, 0, "R3 write ones");
    do_read(SADDR, 2'b00, 0, 0, "R3 flags intact");
    do_read(SADDR, 2'b00, 0, 0, "R4 clear check");

    // R5: event coincident with clearing read
    do_evt(7'h41, "R2 setup");
    do_read(SADDR, 2'b00, 0, 7'h08, "R5 read with event");
    do_read(SADDR, 2'b00, 0, 0, "R5 event survives");

    // R7: armed soft reset, strobe later, event in pulse cycle
    do_evt(7'h3C, "R2 setup");
    do_write(8'h80, 2'b00, 0, 0, "R7 arm");
    idle_cycles(2, 0, "R7 pending");
    evt = 7'h40;
    idle_cycles(1, 1, "R7 pulse at frame end");
    do_read(SADDR, 2'b00, 0, 0, "R7 R6 flags wiped");
    // R7: same-cycle write and strobe
    do_evt(7'h03, "R2 setup");
    do_write(8'hFF, 2'b00, 1, 0, "R7 same cycle pulse");
    do_read(SADDR, 2'b00, 0, 0, "R7 wiped again");
    idle_cycles(1, 1, "R7 disarmed after frame");

    // R8: group and broadcast soft reset ignored
    do_evt(7'h12, "R2 setup");
    do_write(8'h80, 2'b01, 1, 0, "R8 group ignored");
    do_write(8'h80, 2'b10, 0, 0, "R8 broadcast ignored");
    idle_cycles(1, 1, "R8 no pulse");
    do_read(SADDR, 2'b00, 0, 0, "R8 flags kept");

    // R9: startup clears and cancels pending
    do_evt(7'h7F, "R2 setup");
    do_write(8'h80, 2'b00, 0, 0, "R9 arm");
    startup = 1; evt = 7'h01;
    tick("R9 startup");
    idle_cycles(1, 1, "R9 no pulse after cancel");
    do_read(SADDR, 2'b00, 0, 0, "R9 flags wiped");

    // R10: other-address reads
    do_read(5'h05, 2'b00, 0, 0, "R10 disabled read silent");
    do_read(SADDR, 2'b00, 0, 0, "R10 unmapped flag set");
    do_read(5'h05, 2'b00, 1, 0, "R10 enabled read");
    do_read(SADDR, 2'b00, 0, 0, "R10 no flag when enabled");

    // R11: group / broadcast reads of status
    do_evt(7'h21, "R2 setup");
    do_read(SADDR, 2'b01, 0, 0, "R11 group read");
    do_read(SADDR, 2'b10, 0, 0, "R11 broadcast read");
    do_read(SADDR, 2'b00, 0, 0, "R11 flags not cleared");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      acc_valid = ($urandom % 3) == 0;
      acc_write = $urandom % 2;
      acc_addr  = ($urandom % 2) ? SADDR : 5'($urandom);
      acc_wdata = 8'($urandom);
      acc_id    = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      frame_end = ($urandom % 4) == 0;
      rd_en     = $urandom % 2;
      startup   = ($urandom % 50) == 0;
      evt       = (($urandom % 3) == 0) ? 7'($urandom) : 7'h0;
      tick("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule